// File: doc/BRIEF.md
# Synchronous Byte Serial Port with Slave Ready Handshake

This block moves one byte at a time over a three-wire synchronous link (shift clock, serial in, serial out) for a small processor with a 4-bit register bus. In master mode it makes the shift clock itself and drives it out with an output enable. In slave mode it takes the shift clock from the pin. Software picks which clock edge samples the input. A build-time polarity parameter reverses that choice and also sets the idle levels of the clock and of the ready output. Software also picks whether bit 7 or bit 0 goes first. The same order applies in both directions.

The byte register is reached as two nibbles. A transfer is started by a trigger bit, and a busy bit reports that it is still running. At the end of a transfer an interrupt flag is set. The interrupt output follows that flag only while its enable bit is set. In slave mode a ready output tells the external master that it may begin clocking. Ready is set by the trigger and dropped at the first active clock level or at any access to the high nibble.

Top module: `sio_nibble_port`

## Requirements
- R1: After reset, the control and interrupt registers read 0, `irq` and `sclk_oe` are low, and `rdy_out` sits at its inactive level (high when `NEG_POL`=1).
- R2: Register map on `reg_addr`. Address 0 is control: bit0 master, bit1 edge select, bit2 MSB first, bit3 trigger on write and busy on read. Address 1: bit0 flag (writing 1 clears it), bit1 interrupt enable. Address 2: data bits 3..0. Address 3: data bits 7..4. Written fields read back unchanged.
- R3: In master mode `sclk_oe` is high. The clock idles at its idle level (high when `NEG_POL`=1, low otherwise), toggles every `CLK_DIV` system clocks while busy, and is back at idle once the transfer ends.
- R4: With `NEG_POL`=1, edge select 1 samples on the falling clock edge and 0 on the rising edge. With `NEG_POL`=0 this mapping is swapped.
- R5: The first transmitted bit appears on `sdo` at the trigger. Later bits change only on the edge opposite the sampling edge, after at least one sample. MSB first sends bit 7 first. LSB first sends bit 0 first.
- R6: In slave mode the external clock and serial input pass through two-flop synchronizers. Received bits are assembled so that the byte read back equals the byte the peer sent in the chosen order. The system clock must run at least 4x the serial clock.
- R7: The busy bit reads 1 from the cycle after the trigger write until after the eighth sample.
- R8: The flag is set when the eighth bit is sampled, whatever the enable bit holds. `irq` is high only while both flag and enable are 1.
- R9: In slave mode, a trigger write sets ready on the next cycle. A trigger in master mode leaves ready inactive.
- R10: Ready drops within three system clocks once the clock pin reaches its active level (low when `NEG_POL`=1).
- R11: Any read or write of the high data nibble (address 3) drops ready.
- R12: With `NEG_POL`=1, `rdy_out` is driven low when ready and high otherwise. With `NEG_POL`=0 it is the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 4 | Write data nibble |
| reg_rdata | output | 4 | Read data nibble (combinational on address) |
| sclk_in | input | 1 | Shift clock from pin (slave mode) |
| sclk_out | output | 1 | Generated shift clock (master mode) |
| sclk_oe | output | 1 | Drive enable for the clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rdy_out | output | 1 | Slave ready handshake, polarity per `NEG_POL` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest window to reach is the slave-mode gap after a trigger and before the first clock edge. In that gap ready is active and a high-nibble access must drop it while the transfer stays armed and still completes. The bench acts as the external peer. It holds its clock idle, optionally reads the high nibble, and only then clocks out eight periods. It mixes this with random mode, edge, order and data choices. The peer samples and drives on edges it derives from the edge rule, so a wrong sampling edge or bit order shows up as corrupted data in one direction or the other.

// File: rtl/sio_pkg.sv
// Package: register addresses and field positions shared by the serial port.
// Assumes a 4-bit register bus with a 2-bit address.
package sio_pkg;
    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_IRQ  = 2'd1,
        A_DLO  = 2'd2,
        A_DHI  = 2'd3
    } sio_addr_e;

    localparam int C_MASTER = 0;
    localparam int C_EDGE   = 1;
    localparam int C_MSBF   = 2;
    localparam int C_GO     = 3;

    localparam int I_FLAG   = 0;
    localparam int I_EN     = 1;
endpackage

// File: rtl/sio_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; the reset value is chosen by the parent.
module sio_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // capture the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) st[0] <= RST_VAL;
                    else        st[0] <= d;
                end
            end else begin : g_next
                // pass along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) st[g] <= RST_VAL;
                    else        st[g] <= st[g-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/sio_clk_unit.sv
// Shift clock source and edge classifier.
// Master: divides the system clock to make the shift clock while busy.
// Slave: detects edges of the synchronized pin clock while busy.
// Emits one-cycle sample and shift events according to polarity and edge select.
// Assumes CLK_DIV >= 3 so synchronized serial input settles before sampling.
module sio_clk_unit #(
    parameter bit NEG_POL = 1'b1,
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic busy,
    input  logic edge_sel,
    input  logic sclk_s,
    output logic sclk_out,
    output logic samp_ev,
    output logic shft_ev
);
    localparam int   DIV_W    = $clog2(CLK_DIV + 1);
    localparam logic IDLE_LVL = NEG_POL ? 1'b1 : 1'b0;

    logic [DIV_W-1:0] div_q;
    logic             sclk_q;
    logic             s_prev;
    logic             tick, m_rise, m_fall, s_rise, s_fall, rise, fall, samp_fall;

    // divider and generated clock, held at idle whenever not transferring as master
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= IDLE_LVL;
        end else if (!(master && busy)) begin
            div_q  <= '0;
            sclk_q <= IDLE_LVL;
        end else if (div_q == DIV_W'(CLK_DIV - 1)) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

    // previous synchronized pin level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) s_prev <= IDLE_LVL;
        else        s_prev <= sclk_s;
    end

    // classify edges from whichever clock source is active
    always_comb begin
        tick      = master && busy && (div_q == DIV_W'(CLK_DIV - 1));
        m_rise    = tick && !sclk_q;
        m_fall    = tick &&  sclk_q;
        s_rise    = busy &&  sclk_s && !s_prev;
        s_fall    = busy && !sclk_s &&  s_prev;
        rise      = master ? m_rise : s_rise;
        fall      = master ? m_fall : s_fall;
        samp_fall = NEG_POL ? edge_sel : ~edge_sel;
        samp_ev   = samp_fall ? fall : rise;
        shft_ev   = samp_fall ? rise : fall;
    end

    assign sclk_out = sclk_q;
endmodule

// File: rtl/sio_shift_unit.sv
// Byte shift register with output latch, bit counter and busy tracking.
// Assumes W is even; software writes nibbles, serial events shift while busy.
module sio_shift_unit #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           go_msb,
    input  logic           msb_first,
    input  logic           samp_ev,
    input  logic           shft_ev,
    input  logic           din,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W/2-1:0] wnib,
    output logic [W-1:0]   data,
    output logic           sdo,
    output logic           busy,
    output logic           done
);
    localparam int NIB = W / 2;
    localparam int CW  = $clog2(W + 1);

    logic [W-1:0]  shreg;
    logic [CW-1:0] cnt;

    function automatic logic head(input logic [W-1:0] d, input logic msb);
        return msb ? d[W-1] : d[0];
    endfunction

    assign done = busy && samp_ev && (cnt == CW'(W - 1));

    // shift on samples while busy, otherwise accept nibble writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (busy && samp_ev) begin
            shreg <= msb_first ? {shreg[W-2:0], din} : {din, shreg[W-1:1]};
        end else begin
            if (wr_lo) shreg[NIB-1:0] <= wnib;
            if (wr_hi) shreg[W-1:NIB] <= wnib;
        end
    end

    // transfer state: busy flag and sample counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy && samp_ev) begin
            if (done) busy <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    // output latch: first bit at trigger, then on opposite edges after a sample
    always_ff @(posedge clk) begin
        if (!rst_n)                           sdo <= 1'b0;
        else if (go)                          sdo <= head(shreg, go_msb);
        else if (busy && shft_ev && cnt != 0) sdo <= head(shreg, msb_first);
    end

    assign data = shreg;
endmodule

// File: rtl/sio_nibble_port.sv
// Top of the synchronous byte serial port.
// Holds the software registers, the interrupt flag and the slave ready handshake,
// and joins the synchronizer, clock unit and shift unit.
// Assumes a 4-bit register bus; reads are combinational on the address.
module sio_nibble_port #(
    parameter bit NEG_POL = 1'b1,
    parameter int CLK_DIV = 4,
    parameter int DATA_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [DATA_W/2-1:0] reg_wdata,
    output logic [DATA_W/2-1:0] reg_rdata,
    input  logic                sclk_in,
    output logic                sclk_out,
    output logic                sclk_oe,
    input  logic                sdi,
    output logic                sdo,
    output logic                rdy_out,
    output logic                irq
);
    import sio_pkg::*;

    localparam int   NIB      = DATA_W / 2;
    localparam logic IDLE_LVL = NEG_POL ? 1'b1 : 1'b0;
    localparam logic ACT_LVL  = ~IDLE_LVL;

    logic master_q, edge_q, msbf_q, flag_q, en_q, rdy_q;
    logic go, wr_lo, wr_hi, hi_touch, wr_ctrl, wr_irq;
    logic sclk_s, sdi_s, samp_ev, shft_ev, busy, done;
    logic [DATA_W-1:0] data;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_irq   = reg_wr && (reg_addr == A_IRQ);
    assign wr_lo    = reg_wr && (reg_addr == A_DLO);
    assign wr_hi    = reg_wr && (reg_addr == A_DHI);
    assign go       = wr_ctrl && reg_wdata[C_GO];
    assign hi_touch = (reg_wr || reg_rd) && (reg_addr == A_DHI);

    sio_sync #(.W(2), .STAGES(2), .RST_VAL({IDLE_LVL, 1'b0})) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sclk_in, sdi}),
        .q({sclk_s, sdi_s})
    );

    sio_clk_unit #(.NEG_POL(NEG_POL), .CLK_DIV(CLK_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n),
        .master(master_q), .busy(busy), .edge_sel(edge_q), .sclk_s(sclk_s),
        .sclk_out(sclk_out), .samp_ev(samp_ev), .shft_ev(shft_ev)
    );

    sio_shift_unit #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_msb(reg_wdata[C_MSBF]), .msb_first(msbf_q),
        .samp_ev(samp_ev), .shft_ev(shft_ev), .din(sdi_s),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wnib(reg_wdata),
        .data(data), .sdo(sdo), .busy(busy), .done(done)
    );

    // control register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            edge_q   <= 1'b0;
            msbf_q   <= 1'b0;
        end else if (wr_ctrl) begin
            master_q <= reg_wdata[C_MASTER];
            edge_q   <= reg_wdata[C_EDGE];
            msbf_q   <= reg_wdata[C_MSBF];
        end
    end

    // interrupt flag (set wins over clear) and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (done)                             flag_q <= 1'b1;
            else if (wr_irq && reg_wdata[I_FLAG]) flag_q <= 1'b0;
            if (wr_irq) en_q <= reg_wdata[I_EN];
        end
    end

    // slave ready: set by trigger, dropped by high nibble access or active clock level
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdy_q <= 1'b0;
        else if (go)                               rdy_q <= ~reg_wdata[C_MASTER];
        else if (hi_touch)                         rdy_q <= 1'b0;
        else if (master_q || (sclk_s == ACT_LVL))  rdy_q <= 1'b0;
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_MASTER] = master_q;
                reg_rdata[C_EDGE]   = edge_q;
                reg_rdata[C_MSBF]   = msbf_q;
                reg_rdata[C_GO]     = busy;
            end
            A_IRQ: begin
                reg_rdata[I_FLAG] = flag_q;
                reg_rdata[I_EN]   = en_q;
            end
            A_DLO:   reg_rdata = data[NIB-1:0];
            default: reg_rdata = data[DATA_W-1:NIB];
        endcase
    end

    assign sclk_oe = master_q;
    assign rdy_out = NEG_POL ? ~rdy_q : rdy_q;
    assign irq     = flag_q && en_q;
endmodule

// File: rtl/sio_port_checker.sv
// Temporal checks on the serial port, attached by bind to the top module.
// Assumes the register map of sio_pkg.
module sio_port_checker #(
    parameter bit NEG_POL = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_wdata,
    input logic       sclk_out,
    input logic       sclk_oe,
    input logic       rdy_out,
    input logic       irq,
    input logic       busy,
    input logic       flag
);
    localparam logic IDLE_LVL = NEG_POL ? 1'b1 : 1'b0;

    logic rdy_act, go_wr;
    assign rdy_act = NEG_POL ? ~rdy_out : rdy_out;
    assign go_wr   = reg_wr && (reg_addr == 2'd0) && reg_wdata[3];

    p_idle_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && !busy) |=> (sclk_out == IDLE_LVL));

    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_wr));

    p_flag_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(busy));

    p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && !reg_wdata[1]) |=> !irq);

    p_ready_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_act) |-> $past(go_wr && !reg_wdata[0]));

    p_ready_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && reg_addr == 2'd3) |=> !rdy_act);
endmodule

bind sio_nibble_port sio_port_checker #(.NEG_POL(NEG_POL)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .rdy_out(rdy_out), .irq(irq), .busy(busy), .flag(flag_q)
);

// File: tb/sio_nibble_port_test.sv
// Bench: acts as the external serial peer in both modes, random plus directed cases.
module sio_nibble_port_test;
    localparam bit NEG     = 1'b1;
    localparam int DIV     = 4;
    localparam int HALF_SL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       bclk = 1'b1;
    logic       sclk_out, sclk_oe, sdo, rdy_out, irq;
    logic       sdi = 1'b0;
    wire        line_clk = sclk_oe ? sclk_out : bclk;

    int checks = 0, fails = 0;

    // peer state
    bit       peer_on = 0, p_msbf = 0, p_sfall = 0;
    logic [7:0] peer_tx = '0, seq = '0;
    int       pk = 0, ecount = 0;
    time      t0 = 0, t1 = 0;

    sio_nibble_port #(.NEG_POL(NEG), .CLK_DIV(DIV), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_in(bclk), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi),
        .sdo(sdo), .rdy_out(rdy_out), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic pbit(input int k);
        return p_msbf ? peer_tx[7-k] : peer_tx[k];
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // peer: samples sdo on the sampling edge, drives sdi on the opposite edge
    always @(line_clk) begin
        if (peer_on) begin
            if (ecount == 0) t0 = $time;
            if (ecount == 1) t1 = $time;
            ecount++;
            if (pk < 8) begin
                if ((line_clk == 1'b0) == p_sfall) begin
                    #1;
                    seq = {seq[6:0], sdo};
                    pk++;
                end else if (pk > 0) begin
                    sdi = pbit(pk);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic xfer(input bit m, input bit e, input bit o, input logic [7:0] tx,
                        input logic [7:0] pb, input bit en, input bit hi);
        logic [3:0] v, lo;
        wr(2'd0, {1'b0, o, e, m});
        wr(2'd1, {2'b00, en, 1'b1});
        wr(2'd2, tx[3:0]);
        wr(2'd3, tx[7:4]);
        rd(2'd0, v);
        chk(v == {1'b0, o, e, m}, "R2 ctrl readback", v, {1'b0, o, e, m});
        rd(2'd2, v);
        chk(v == tx[3:0], "R2 data low readback", v, tx[3:0]);
        peer_tx = pb; p_msbf = o; p_sfall = NEG ? e : ~e;
        pk = 0; seq = '0; ecount = 0;
        sdi = pbit(0);
        peer_on = 1;
        wr(2'd0, {1'b1, o, e, m});
        if (!m) chk(rdy_out == 1'b0, "R9 R12 ready after trigger", rdy_out, 0);
        else    chk(rdy_out == 1'b1, "R9 no ready in master", rdy_out, 1);
        rd(2'd0, v);
        chk(v[3] == 1'b1, "R7 busy after trigger", v[3], 1);
        if (!m) begin
            if (hi) begin
                rd(2'd3, v);
                chk(rdy_out == 1'b1, "R11 ready dropped by high nibble", rdy_out, 1);
            end else begin
                chk(rdy_out == 1'b0, "R10 ready held before clock", rdy_out, 0);
            end
            repeat (4) @(negedge clk);
            for (int i = 0; i < 16; i++) begin
                bclk = ~bclk;
                repeat (HALF_SL) @(negedge clk);
                if (i == 0) chk(rdy_out == 1'b1, "R10 ready dropped by clock", rdy_out, 1);
            end
        end
        v = 4'hF;
        for (int k = 0; k < 200 && v[3]; k++) rd(2'd0, v);
        chk(v[3] == 1'b0, "R7 busy cleared", v[3], 0);
        repeat (4) @(negedge clk);
        if (m) begin
            chk((t1 - t0) == DIV * 20, "R3 half period", int'(t1 - t0), DIV * 20);
            chk(sclk_out == NEG && sclk_oe, "R3 idle level", sclk_out, NEG);
        end
        rd(2'd2, lo);
        rd(2'd3, v);
        chk({v, lo} == pb, "R4 R6 received byte", {v, lo}, pb);
        chk(seq == (o ? tx : rev8(tx)), "R5 wire order", seq, o ? tx : rev8(tx));
        rd(2'd1, v);
        chk(v[0] == 1'b1, "R8 flag set", v[0], 1);
        chk(irq == en, "R8 irq gated", irq, en);
        wr(2'd1, {2'b00, en, 1'b1});
        rd(2'd1, v);
        chk(v[0] == 1'b0 && irq == 1'b0, "R8 flag cleared", {v[0], irq}, 0);
        peer_on = 0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 0);
        $finish;
    end

    initial begin
        logic [3:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0 && sclk_oe == 1'b0, "R1 outputs after reset", {irq, sclk_oe}, 0);
        chk(rdy_out == NEG, "R1 R12 ready inactive", rdy_out, NEG);
        rd(2'd0, v);
        chk(v == 4'h0, "R1 ctrl reset", v, 0);
        rd(2'd1, v);
        chk(v == 4'h0, "R1 irq reset", v, 0);
        // directed corners: every mode/edge/order combination
        xfer(1, 0, 0, 8'hA5, 8'h3C, 1, 0);
        xfer(1, 1, 1, 8'h81, 8'h7E, 0, 0);
        xfer(1, 0, 1, 8'h01, 8'h80, 1, 0);
        xfer(1, 1, 0, 8'hFE, 8'h01, 0, 0);
        xfer(0, 0, 1, 8'hC3, 8'h96, 1, 0);
        xfer(0, 1, 0, 8'h5A, 8'hE1, 0, 0);
        xfer(0, 1, 1, 8'h0F, 8'hF0, 1, 1);
        xfer(0, 0, 0, 8'h00, 8'hFF, 0, 1);
        // random mix
        for (int n = 0; n < 24; n++) begin
            logic [31:0] r = $urandom;
            xfer(r[0], r[1], r[2], r[15:8], r[23:16], r[3], r[5:4] == 2'b00);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule